// File: doc/BRIEF.md
# Key-Unlock and Init-Mode Register Guard

This block sits between a register write port and the counting core of a timekeeping peripheral and decides which writes reach it. Protected writes pass only after a two-byte unlock key has been written, in order, to a write-only key register. Any other key write closes the guard again.

Loading the time and date, or changing the prescaler, also needs init mode. Software sets an init request bit. After a fixed number of calendar ticks, the block raises an acknowledge and holds the calendar frozen. Time and date writes are then forwarded to the core as one-cycle load strobes.

The block keeps read shadows of the running time and date. These are refreshed on each calendar tick outside init mode. A sync flag lets software see that a refresh has happened since it last cleared the flag. A sticky flag records whether a date has ever been loaded.

Top module: `key_init_guard`

## Requirements
- R1: After reset the guard is locked, `frozen` is 0, the status word and both shadows read 0, and the prescaler reads `PRESC_RST`.
- R2: The key register is address 4, and its low byte is compared. Writing 0xCA and then 0x53, with any cycles between them but no other key write, sets `unlocked`.
- R3: Any other key byte relocks the guard. This holds in every state, including a second 0xCA after the first and any key write while the guard is open.
- R4: While locked, writes to the init request bit, to the prescaler (address 3), to time (address 0) and to date (address 1) have no effect.
- R5: The key register reads as 0.
- R6: The status register is address 2 and bit 7 is the init request. Bit 6 (`frozen`) rises on the edge of the second tick sampled while the request is already set. Clearing bit 7 with an unlocked write drops the acknowledge on the same edge.
- R7: `load_time` and `load_date` pulse, and the prescaler updates, only for writes made while the guard is both unlocked and acknowledged.
- R8: Status bit 5 is the sync flag. Any status write with bit 5 at 0 clears it, whether locked or not. A clear in the same cycle as a tick wins over the set. Otherwise the flag sets on a tick outside init mode, and the shadows capture `cal_time` and `cal_date` on that tick.
- R9: Status bit 4 sets on the first date load and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle calendar clock enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| cal_time | input | DW | Running time from the calendar core |
| cal_date | input | DW | Running date from the calendar core |
| rdata | output | DW | Read data for `addr` |
| unlocked | output | 1 | Key sequence completed |
| frozen | output | 1 | Init mode acknowledged, calendar held |
| load_time | output | 1 | Load strobe for time |
| load_date | output | 1 | Load strobe for date |
| load_data | output | DW | Value to load |
| presc_val | output | DW | Current prescaler setting |

## Verification
The hardest situations to reach are edges where a tick coincides with something else. One is a tick landing in the same cycle as a sync-flag clear. Another is a tick arriving in the very cycle the init request is written, which must not count toward the acknowledge. The bench drives `tick` directly on each cycle, so it can place ticks in those exact cycles. A behavioural model, updated on every edge, predicts the flag, the shadows and the acknowledge. Key sequences are interleaved with protected writes, so gating is observed both open and closed.

// File: rtl/key_init_guard.sv
module key_init_guard #(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter logic [7:0] KEY_A = 8'hCA,
  parameter logic [7:0] KEY_B = 8'h53,
  parameter int ACK_TICKS = 2,
  parameter logic [DW-1:0] PRESC_RST = 32'h007F00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cal_time,
  input  logic [DW-1:0] cal_date,
  output logic [DW-1:0] rdata,
  output logic          unlocked,
  output logic          frozen,
  output logic          load_time,
  output logic          load_date,
  output logic [DW-1:0] load_data,
  output logic [DW-1:0] presc_val
);
  localparam int CW = (ACK_TICKS > 1) ? $clog2(ACK_TICKS) : 1;
  localparam logic [AW-1:0] A_TIME  = AW'(0);
  localparam logic [AW-1:0] A_DATE  = AW'(1);
  localparam logic [AW-1:0] A_STAT  = AW'(2);
  localparam logic [AW-1:0] A_PRESC = AW'(3);
  localparam logic [AW-1:0] A_KEY   = AW'(4);

  typedef enum logic [1:0] {K_SHUT, K_HALF, K_OPEN} kst_t;

  kst_t          kst;
  logic          req_q, ack_q, sync_q, inits_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] shd_time, shd_date, presc_q;

  wire wr_key   = wr_en && addr == A_KEY;
  wire wr_stat  = wr_en && addr == A_STAT;
  wire gate     = unlocked && ack_q;
  wire req_drop = wr_stat && unlocked && !wdata[7];
  wire refresh  = tick && !ack_q;

  assign unlocked  = kst == K_OPEN;
  assign frozen    = ack_q;
  assign load_time = wr_en && addr == A_TIME && gate;
  assign load_date = wr_en && addr == A_DATE && gate;
  assign load_data = wdata;
  assign presc_val = presc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) kst <= K_SHUT;
    else if (wr_key)
      case (kst)
        K_SHUT:  kst <= (wdata[7:0] == KEY_A) ? K_HALF : K_SHUT;
        K_HALF:  kst <= (wdata[7:0] == KEY_B) ? K_OPEN : K_SHUT;
        default: kst <= K_SHUT;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_stat && unlocked) req_q <= wdata[7];
      if (req_drop) begin
        ack_q <= 1'b0;
        cnt_q <= '0;
      end else if (tick && req_q && !ack_q) begin
        if (cnt_q == CW'(ACK_TICKS - 1)) ack_q <= 1'b1;
        else cnt_q <= cnt_q + CW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q   <= 1'b0;
      shd_time <= '0;
      shd_date <= '0;
    end else begin
      if (wr_stat && !wdata[5]) sync_q <= 1'b0;
      else if (refresh) sync_q <= 1'b1;
      if (refresh) begin
        shd_time <= cal_time;
        shd_date <= cal_date;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      presc_q <= PRESC_RST;
      inits_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_PRESC && gate) presc_q <= wdata;
      if (load_date) inits_q <= 1'b1;
    end

  always_comb
    case (addr)
      A_TIME:  rdata = shd_time;
      A_DATE:  rdata = shd_date;
      A_STAT:  rdata = {{(DW-8){1'b0}}, req_q, ack_q, sync_q, inits_q, 4'b0};
      A_PRESC: rdata = presc_q;
      default: rdata = '0;
    endcase

  AST_OPEN_BY_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_key && wdata[7:0] == KEY_B)); // R2
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_key) |=> !unlocked); // R3
  AST_PRESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(presc_q)); // R4
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> req_q); // R6
  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_time || load_date) |-> (unlocked && frozen)); // R7
  AST_SYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(tick)); // R8
  AST_INITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    inits_q |=> inits_q); // R9
endmodule

// File: tb/sim_key_init_guard.sv
module sim_key_init_guard;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, cal_time = 0, cal_date = 0;
  logic [31:0] rdata, load_data, presc_val;
  logic unlocked, frozen, load_time, load_date;
  int checks = 0, errors = 0, ncyc = 0;
  string tag = "R1";

  int mst, mcnt;
  bit mreq, mack, msync, minits;
  logic [31:0] mtime, mdate, mpresc;

  always #10 clk = ~clk;

  key_init_guard u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cal_time(cal_time), .cal_date(cal_date), .rdata(rdata),
    .unlocked(unlocked), .frozen(frozen), .load_time(load_time), .load_date(load_date),
    .load_data(load_data), .presc_val(presc_val));

  task automatic expect32(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rdata(input logic [2:0] a);
    case (a)
      3'd0: return mtime;
      3'd1: return mdate;
      3'd2: return {24'b0, mreq, mack, msync, minits, 4'b0};
      3'd3: return mpresc;
      default: return 32'b0;
    endcase
  endfunction

  task automatic compare();
    bit gate = (mst == 2) && mack;
    expect32({tag, " rdata"}, rdata, model_rdata(addr));
    expect32({tag, " unlocked"}, {31'b0, unlocked}, {31'b0, mst == 2});
    expect32({tag, " frozen"}, {31'b0, frozen}, {31'b0, mack});
    expect32({tag, " load_time"}, {31'b0, load_time}, {31'b0, wr_en && addr == 0 && gate});
    expect32({tag, " load_date"}, {31'b0, load_date}, {31'b0, wr_en && addr == 1 && gate});
    expect32({tag, " presc"}, presc_val, mpresc);
  endtask

  task automatic model_step();
    bit gate = (mst == 2) && mack;
    int nst = mst, ncnt = mcnt;
    bit nreq = mreq, nack = mack, nsync = msync;
    if (wr_en && addr == 4) begin
      if (mst == 0) nst = (wdata[7:0] == 8'hCA) ? 1 : 0;
      else if (mst == 1) nst = (wdata[7:0] == 8'h53) ? 2 : 0;
      else nst = 0;
    end
    if (wr_en && addr == 2 && mst == 2) nreq = wdata[7];
    if (wr_en && addr == 2 && mst == 2 && !wdata[7]) begin
      nack = 0; ncnt = 0;
    end else if (tick && mreq && !mack) begin
      if (mcnt == 1) nack = 1; else ncnt = mcnt + 1;
    end
    if (wr_en && addr == 2 && !wdata[5]) nsync = 0;
    else if (tick && !mack) nsync = 1;
    if (tick && !mack) begin
      mtime = cal_time; mdate = cal_date;
    end
    if (wr_en && addr == 3 && gate) mpresc = wdata;
    if (wr_en && addr == 1 && gate) minits = 1;
    mst = nst; mcnt = ncnt; mreq = nreq; mack = nack; msync = nsync;
  endtask

  task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] d, input bit t);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = t;
    ncyc++;
    cal_time = 32'h0012_0000 + ncyc;
    cal_date = 32'h0024_0100 ^ (ncyc * 7);
    #1 compare();
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(input logic [2:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(0, a, 0, 0);
  endtask

  task automatic unlock();
    cyc(1, 4, 32'hCA, 0);
    cyc(1, 4, 32'h53, 0);
  endtask

  initial begin
    mst = 0; mcnt = 0; mreq = 0; mack = 0; msync = 0; minits = 0;
    mtime = 0; mdate = 0; mpresc = 32'h007F00FF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    tag = "R1";
    for (int a = 0; a < 5; a++) idle(a[2:0], 1);
    expect32("R1 presc reset", presc_val, 32'h007F00FF);
    expect32("R1 locked", {31'b0, unlocked}, 0);

    tag = "R4";
    cyc(1, 2, 32'hA0, 0); cyc(1, 3, 32'h1234, 0);
    cyc(1, 0, 32'h111, 0); cyc(1, 1, 32'h222, 0);
    idle(2, 1);
    expect32("R4 req ignored", rdata, 32'h0);

    tag = "R2"; unlock(); idle(4, 1);
    expect32("R2 open", {31'b0, unlocked}, 1);
    tag = "R5"; idle(4, 1);
    expect32("R5 key reads 0", rdata, 0);

    tag = "R3";
    cyc(1, 4, 32'hFF, 0); idle(2, 1);
    expect32("R3 relock", {31'b0, unlocked}, 0);
    cyc(1, 4, 32'hCA, 0); cyc(1, 4, 32'h12, 0); cyc(1, 4, 32'h53, 0); idle(2, 1);
    expect32("R3 wrong second", {31'b0, unlocked}, 0);
    cyc(1, 4, 32'hCA, 0); cyc(1, 4, 32'hCA, 0); cyc(1, 4, 32'h53, 0); idle(2, 1);
    expect32("R3 repeated first", {31'b0, unlocked}, 0);
    unlock(); cyc(1, 4, 32'hCA, 0); idle(2, 1);
    expect32("R3 open then CA", {31'b0, unlocked}, 0);

    tag = "R8";
    cyc(0, 2, 0, 1); idle(0, 1);
    cyc(1, 2, 32'h00, 0); cyc(0, 2, 0, 0); cyc(1, 2, 32'h00, 1);
    idle(2, 1);
    expect32("R8 clear beats tick", rdata & 32'h20, 0);
    cyc(0, 2, 0, 1); idle(2, 1);
    expect32("R8 set on tick", rdata & 32'h20, 32'h20);
    idle(0, 1); idle(1, 1);

    tag = "R7"; unlock();
    cyc(1, 0, 32'h55, 0); cyc(1, 3, 32'h99, 0);
    tag = "R6";
    cyc(1, 2, 32'hA0, 1); cyc(0, 2, 0, 0); cyc(0, 2, 0, 1);
    expect32("R6 not yet", {31'b0, frozen}, 0);
    cyc(0, 2, 0, 0); cyc(0, 2, 0, 1);
    expect32("R6 still not", {31'b0, frozen}, 0);
    idle(2, 1);
    expect32("R6 ack risen", {31'b0, frozen}, 1);
    tag = "R8"; cyc(0, 0, 0, 1); cyc(0, 1, 0, 1); idle(0, 1);
    tag = "R7";
    cyc(1, 0, 32'h0012_3456, 0); cyc(1, 3, 32'h00FF_0080, 0);
    tag = "R9"; cyc(1, 1, 32'h0017_0512, 0); idle(2, 1);
    expect32("R9 inits set", rdata & 32'h10, 32'h10);
    tag = "R6"; cyc(1, 2, 32'h20, 1); idle(2, 1);
    expect32("R6 drop", {31'b0, frozen}, 0);
    tag = "R9"; cyc(1, 4, 32'hFF, 1); idle(2, 1);
    expect32("R9 sticky", rdata & 32'h10, 32'h10);
    tag = "R4"; cyc(1, 3, 32'h5, 0); idle(3, 1);
    expect32("R4 presc locked", presc_val, 32'h00FF_0080);
    for (int i = 0; i < 6; i++) cyc(0, i[2:0] % 3'd4, 0, i[0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule